// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block picks which of five interrupt sources a small microcontroller core should service next. The sources are two external request flags, two timer overflow flags and a serial source that is raised when either the receive-done or the transmit-done flag is set. The flag registers themselves live outside the block. The core writes an 8-bit enable register and an 8-bit priority register through a simple write port and can read both back at any time.

Among the sources that are enabled and pending, any high-priority source beats any low-priority one. Ties within a level are broken by a fixed polling order. The block raises a request toward the core with a 16-bit vector address and a source index, and holds them steady until the core acknowledges.

Two in-service bits track nesting. A low-level handler can be preempted by a high-level request. A high-level handler cannot be preempted at all. The core's return-from-interrupt pulse closes the most recently opened level. Stack handling, PC loading and instruction completion belong to the core. Here they appear only as the acknowledge and return inputs.

Top module: `irq_arbiter`

## Requirements
- R1: After reset, `en_rd` and `pri_rd` read 0x00, `irq_req` and `irq_hi` are 0, and `irq_vec` reads 0x0000.
- R2: A write with `cfg_sel`=0 loads the enable register and a write with `cfg_sel`=1 loads the priority register, both on the clock edge where `cfg_we` is high. Unused bits read as 0: bits 6 and 5 of the enable register and bits 7..5 of the priority register. Writing 0xFF therefore reads back as 0x9F for enable and 0x1F for priority.
- R3: While enable bit 7 (global) is 0, `irq_req` stays 0 whatever the other enable bits and flags are.
- R4: Enable and priority bits are assigned per source: bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 serial. A source whose enable bit is 0 never produces a request.
- R5: The serial source is pending when `rx_done` or `tx_done` is 1.
- R6: The source index `irq_src` is 0 to 4 in the order of R4. `irq_vec` equals 0x0003 + 8 × index, which gives 0x0003, 0x000B, 0x0013, 0x001B and 0x0023.
- R7: Among pending sources of the same level, the lowest index of R4 wins.
- R8: A pending high-priority source (priority bit 1) wins over every low-priority source, whatever their indices. `irq_hi` reports the level of the request.
- R9: A request is raised only if it outranks every level in service. With low in service, only high-level sources are requested. With high in service, nothing is requested.
- R10: While `irq_req` is 1 and `irq_ack` is 0, `irq_req`, `irq_hi`, `irq_src` and `irq_vec` do not change, even if new sources appear. On the edge where `irq_ack` is 1, the request drops and the level in `irq_hi` enters service.
- R11: A pulse on `irq_ret` clears the high in-service bit if it is set, and otherwise clears the low one. When `irq_ret` and an accepted `irq_ack` share an edge, the return is applied first and the acknowledged level is set afterwards.
- R12: `irq_req` rises on the first clock edge at which a qualifying pending source is presented with no request outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Write target: 0 enable register, 1 priority register |
| cfg_wdata | input | 8 | Write data |
| en_rd | output | 8 | Enable register readback |
| pri_rd | output | 8 | Priority register readback |
| ext0_flag | input | 1 | External request 0 flag |
| tmr0_flag | input | 1 | Timer 0 overflow flag |
| ext1_flag | input | 1 | External request 1 flag |
| tmr1_flag | input | 1 | Timer 1 overflow flag |
| rx_done | input | 1 | Serial receive complete flag |
| tx_done | input | 1 | Serial transmit complete flag |
| irq_req | output | 1 | Interrupt request to the core |
| irq_hi | output | 1 | Level of the presented request (1 = high) |
| irq_src | output | 3 | Index of the presented source |
| irq_vec | output | 16 | Vector address of the presented source |
| irq_ack | input | 1 | Core accepts the presented request |
| irq_ret | input | 1 | Core returns from the current handler |

## Verification
The acknowledge of a new high-level request and the return from the low-level handler it preempted can land on the same clock edge. The two have opposite effects on the in-service bits. The bench opens a low-level handler, presents a high-level request, and then pulses `irq_ack` and `irq_ret` together. It judges the resulting state at the ports. A fresh high-level source must stay unrequested, which shows that high is now in service. A single further return must then let that source through, which shows that the low level was closed by the concurrent return.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC = 5;
  localparam int SRCW = $clog2(NSRC);
  localparam int NLVL = 2;
  typedef logic [SRCW-1:0] src_idx_t;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int NSRC = irq_pkg::NSRC,
  parameter int CFGW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            wr_sel,
  input  logic [CFGW-1:0] wr_data,
  output logic            glob_en,
  output logic [NSRC-1:0] en_mask,
  output logic [NSRC-1:0] pri_mask,
  output logic [CFGW-1:0] en_rd,
  output logic [CFGW-1:0] pri_rd
);
  localparam int GAPW = CFGW - 1 - NSRC;

  logic            glob_q, glob_d;
  logic [NSRC-1:0] en_q, en_d, pri_q, pri_d;
  logic            unused_bits;

  assign unused_bits = ^wr_data[CFGW-2:NSRC];

  always_comb begin
    glob_d = glob_q;
    en_d   = en_q;
    pri_d  = pri_q;
    if (wr_en) begin
      if (!wr_sel) begin
        glob_d = wr_data[CFGW-1];
        en_d   = wr_data[NSRC-1:0];
      end else begin
        pri_d  = wr_data[NSRC-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q <= 1'b0;
      en_q   <= '0;
      pri_q  <= '0;
    end else if (wr_en) begin
      glob_q <= glob_d;
      en_q   <= en_d;
      pri_q  <= pri_d;
    end
  end

  assign glob_en  = glob_q;
  assign en_mask  = en_q;
  assign pri_mask = pri_q;
  assign en_rd    = {glob_q, {GAPW{1'b0}}, en_q};
  assign pri_rd   = {{(CFGW-NSRC){1'b0}}, pri_q};

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_rd) && $stable(pri_rd));
endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int NSRC = irq_pkg::NSRC
) (
  input  logic              [NSRC-1:0] pend,
  input  logic              [NSRC-1:0] pri_mask,
  input  logic              [1:0]      svc,
  output logic                         pick_valid,
  output logic                         pick_hi,
  output irq_pkg::src_idx_t            pick_idx
);
  localparam int SRCW = irq_pkg::SRCW;

  logic [NSRC-1:0] cand [2];
  logic [1:0]      any;
  logic [SRCW-1:0] first [2];

  assign cand[0] = pend & ~pri_mask;
  assign cand[1] = pend &  pri_mask;

  // One fixed-order poller per level
  for (genvar l = 0; l < 2; l++) begin : g_lvl
    always_comb begin
      any[l]   = 1'b0;
      first[l] = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
        if (cand[l][i]) begin
          any[l]   = 1'b1;
          first[l] = SRCW'(i);
        end
      end
    end
  end

  always_comb begin
    pick_valid = 1'b0;
    pick_hi    = 1'b0;
    pick_idx   = first[0];
    if (any[1]) begin
      pick_hi    = 1'b1;
      pick_idx   = first[1];
      pick_valid = !svc[1];
    end else if (any[0]) begin
      pick_valid = (svc == 2'b00);
    end
  end
endmodule

// File: rtl/irq_svc_track.sv
module irq_svc_track (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack,
  input  logic       ack_hi,
  input  logic       ret,
  output logic [1:0] svc
);
  logic [1:0] svc_q, svc_d;

  always_comb begin
    svc_d = svc_q;
    if (ret) begin
      if (svc_d[1]) svc_d[1] = 1'b0;
      else          svc_d[0] = 1'b0;
    end
    if (ack) svc_d[ack_hi] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          svc_q <= 2'b00;
    else if (ack || ret) svc_q <= svc_d;
  end

  assign svc = svc_q;

  // R11
  ret_pops_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack && svc_q == 2'b11) |=> svc_q == 2'b01);

  // R11
  ack_ret_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && ack && ack_hi && svc_q == 2'b01) |=> svc_q == 2'b10);
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int              CFGW     = 8,
  parameter int              VECW     = 16,
  parameter logic [VECW-1:0] VEC_BASE = 16'h0003,
  parameter int              VEC_STEP = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic            cfg_sel,
  input  logic [CFGW-1:0] cfg_wdata,
  output logic [CFGW-1:0] en_rd,
  output logic [CFGW-1:0] pri_rd,
  input  logic            ext0_flag,
  input  logic            tmr0_flag,
  input  logic            ext1_flag,
  input  logic            tmr1_flag,
  input  logic            rx_done,
  input  logic            tx_done,
  output logic            irq_req,
  output logic            irq_hi,
  output logic [2:0]      irq_src,
  output logic [VECW-1:0] irq_vec,
  input  logic            irq_ack,
  input  logic            irq_ret
);
  localparam int NSRC = irq_pkg::NSRC;
  localparam int SRCW = irq_pkg::SRCW;

  logic [1:0]        rs_q;
  logic              rst_s;
  logic              glob_en;
  logic [NSRC-1:0]   en_mask, pri_mask, raw, pend;
  logic [1:0]        svc;
  logic              pick_valid, pick_hi;
  irq_pkg::src_idx_t pick_idx;
  logic              req_q, req_d, hi_q, hi_d, ack_fire;
  logic [SRCW-1:0]   src_q, src_d;
  logic [VECW-1:0]   vec_q, vec_d;

  // Reset asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  irq_cfg_regs #(.NSRC(NSRC), .CFGW(CFGW)) u_cfg (
    .clk(clk), .rst_n(rst_s), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .glob_en(glob_en), .en_mask(en_mask),
    .pri_mask(pri_mask), .en_rd(en_rd), .pri_rd(pri_rd)
  );

  assign raw  = {rx_done | tx_done, tmr1_flag, ext1_flag, tmr0_flag, ext0_flag};
  assign pend = raw & en_mask & {NSRC{glob_en}};

  irq_select #(.NSRC(NSRC)) u_sel (
    .pend(pend), .pri_mask(pri_mask), .svc(svc),
    .pick_valid(pick_valid), .pick_hi(pick_hi), .pick_idx(pick_idx)
  );

  assign ack_fire = req_q & irq_ack;

  irq_svc_track u_svc (
    .clk(clk), .rst_n(rst_s), .ack(ack_fire), .ack_hi(hi_q),
    .ret(irq_ret), .svc(svc)
  );

  always_comb begin
    req_d = req_q;
    hi_d  = hi_q;
    src_d = src_q;
    vec_d = vec_q;
    if (req_q) begin
      if (irq_ack) req_d = 1'b0;
    end else if (pick_valid) begin
      req_d = 1'b1;
      hi_d  = pick_hi;
      src_d = pick_idx;
      vec_d = VEC_BASE + VECW'(pick_idx) * VECW'(VEC_STEP);
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      req_q <= 1'b0;
      hi_q  <= 1'b0;
      src_q <= '0;
      vec_q <= '0;
    end else begin
      req_q <= req_d;
      hi_q  <= hi_d;
      src_q <= src_d;
      vec_q <= vec_d;
    end
  end

  assign irq_req = req_q;
  assign irq_hi  = hi_q;
  assign irq_src = 3'(src_q);
  assign irq_vec = vec_q;

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_req && !irq_ack) |=> irq_req && $stable(irq_vec) && $stable(irq_src) && $stable(irq_hi));

  // R10
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (irq_req && irq_ack) |=> !irq_req);

  // R3
  glob_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(irq_req) |-> $past(en_rd[CFGW-1]));

  // R6
  vec_form_chk: assert property (@(posedge clk) disable iff (!rst_s)
    irq_req |-> (irq_vec[2:0] == 3'b011) && (irq_src < 3'(NSRC)));

  // R9
  no_preempt_hi_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(irq_req) |-> !$past(svc[1]));
endmodule

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  logic clk = 1'b0;
  logic rst_n, cfg_we, cfg_sel;
  logic [7:0] cfg_wdata, en_rd, pri_rd;
  logic ext0, tmr0, ext1, tmr1, rxd, txd;
  logic irq_req, irq_hi, irq_ack, irq_ret;
  logic [2:0] irq_src;
  logic [15:0] irq_vec;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  irq_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .en_rd(en_rd), .pri_rd(pri_rd),
    .ext0_flag(ext0), .tmr0_flag(tmr0), .ext1_flag(ext1), .tmr1_flag(tmr1),
    .rx_done(rxd), .tx_done(txd), .irq_req(irq_req), .irq_hi(irq_hi),
    .irq_src(irq_src), .irq_vec(irq_vec), .irq_ack(irq_ack), .irq_ret(irq_ret)
  );

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_req(string tag, logic exp_req, logic [15:0] exp_vec = 16'h0);
    chk({tag, " req"}, 32'(irq_req), 32'(exp_req));
    if (exp_req) begin
      chk({tag, " vec"}, 32'(irq_vec), 32'(exp_vec));
      chk({tag, " src"}, 32'(irq_src), 32'((exp_vec - 16'h3) >> 3));
    end
  endtask

  task automatic flags(logic [5:0] f);
    {txd, rxd, tmr1, ext1, tmr0, ext0} = f;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    irq_ack = 0; irq_ret = 0; flags(6'b0);
    step(2);
    rst_n = 1'b1;
    step(3);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    step();
    cfg_we = 0;
  endtask

  task automatic ack();
    irq_ack = 1; step(); irq_ack = 0;
  endtask

  task automatic ret();
    irq_ret = 1; step(); irq_ret = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 en_rd", 32'(en_rd), 32'h00);
    chk("R1 pri_rd", 32'(pri_rd), 32'h00);
    chk("R1 req", 32'(irq_req), 32'h0);
    chk("R1 hi", 32'(irq_hi), 32'h0);
    chk("R1 vec", 32'(irq_vec), 32'h0000);
  endtask

  task automatic t_regs();
    do_reset();
    wr(0, 8'hFF);
    chk("R2 en readback", 32'(en_rd), 32'h9F);
    chk("R2 pri untouched", 32'(pri_rd), 32'h00);
    wr(1, 8'hFF);
    chk("R2 pri readback", 32'(pri_rd), 32'h1F);
    chk("R2 en untouched", 32'(en_rd), 32'h9F);
  endtask

  task automatic t_global();
    do_reset();
    wr(0, 8'h1F);
    flags(6'b111111);
    step(3);
    chk("R3 global off", 32'(irq_req), 32'h0);
    wr(0, 8'h9F);
    chk("R12 not yet", 32'(irq_req), 32'h0);
    step();
    chk_req("R12 R7 first edge", 1'b1, 16'h0003);
  endtask

  task automatic t_enable();
    do_reset();
    wr(0, 8'h88);
    flags(6'b111111);
    step(2);
    chk_req("R4 R6 only tmr1", 1'b1, 16'h001B);
    do_reset();
    wr(0, 8'h9B);
    flags(6'b000100);
    step(3);
    chk("R4 ext1 disabled", 32'(irq_req), 32'h0);
  endtask

  task automatic t_serial();
    do_reset();
    wr(0, 8'h90);
    flags(6'b010000);
    step();
    chk_req("R5 R6 rx", 1'b1, 16'h0023);
    do_reset();
    wr(0, 8'h90);
    flags(6'b100000);
    step();
    chk_req("R5 tx", 1'b1, 16'h0023);
  endtask

  task automatic t_order();
    do_reset();
    wr(0, 8'h9F);
    flags(6'b001110);
    step();
    chk_req("R7 tmr0 first", 1'b1, 16'h000B);
    ack();
    chk("R10 drop after ack", 32'(irq_req), 32'h0);
    flags(6'b001100);
    ret();
    step();
    chk_req("R7 R11 ext1 next", 1'b1, 16'h0013);
  endtask

  task automatic t_hi_wins();
    do_reset();
    wr(0, 8'h9F);
    wr(1, 8'h10);
    flags(6'b010001);
    step();
    chk_req("R8 serial high", 1'b1, 16'h0023);
    chk("R8 hi level", 32'(irq_hi), 32'h1);
  endtask

  task automatic t_nest();
    do_reset();
    wr(0, 8'h9F);
    wr(1, 8'h08);
    flags(6'b000001);
    step();
    chk_req("R9 ext0 low", 1'b1, 16'h0003);
    ack();
    flags(6'b000100);
    step(2);
    chk("R9 low blocks low", 32'(irq_req), 32'h0);
    flags(6'b001100);
    step();
    chk_req("R9 high preempts", 1'b1, 16'h001B);
    ack();
    flags(6'b000100);
    step(2);
    chk("R9 high blocks all", 32'(irq_req), 32'h0);
    ret();
    step();
    chk("R11 low still in service", 32'(irq_req), 32'h0);
    ret();
    step();
    chk_req("R11 both closed", 1'b1, 16'h0013);
  endtask

  task automatic t_hold();
    do_reset();
    wr(0, 8'h9F);
    flags(6'b001000);
    step();
    chk_req("R10 tmr1", 1'b1, 16'h001B);
    flags(6'b001001);
    step(3);
    chk_req("R10 held vs ext0", 1'b1, 16'h001B);
    wr(1, 8'h01);
    step();
    chk_req("R10 held vs high", 1'b1, 16'h001B);
    chk("R10 level held", 32'(irq_hi), 32'h0);
    flags(6'b0);
    ack();
    chk("R10 drop", 32'(irq_req), 32'h0);
  endtask

  task automatic t_ack_ret();
    do_reset();
    wr(0, 8'h9F);
    wr(1, 8'h01);
    flags(6'b000010);
    step();
    chk_req("R11 tmr0 low", 1'b1, 16'h000B);
    ack();
    flags(6'b000001);
    step();
    chk_req("R11 ext0 high", 1'b1, 16'h0003);
    irq_ack = 1; irq_ret = 1;
    step();
    irq_ack = 0; irq_ret = 0;
    flags(6'b0);
    step();
    flags(6'b000001);
    step(2);
    chk("R11 concurrent leaves high busy", 32'(irq_req), 32'h0);
    ret();
    step();
    chk_req("R11 one return frees all", 1'b1, 16'h0003);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_regs();
    t_global();
    t_enable();
    t_serial();
    t_order();
    t_hi_wins();
    t_nest();
    t_hold();
    t_ack_ret();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule